// File: doc/BRIEF.md
# Packed 128-bit SIMD Execution Unit

This unit is one execution stage of a 128-bit multimedia datapath. Each cycle it can accept two 128-bit source operands, a 5-bit destination register index and a 4-bit operation code. One clock later it presents the result, the destination index and a writeback enable. The register file and the instruction decoder sit outside the unit. Two flags tell the unit that a source was read from register 0, and the unit then treats that operand as all zeros.

The unit splits the data into two independent 64-bit halves. It supports lane-wise subtraction on 8-, 16- and 32-bit lanes and the four bitwise logic functions. It also supports four permutes that move halfwords, words and doublewords within a half or between halves. A destination index of zero turns the operation into a no-op for writeback.

Top module: `simd_exec_unit`

## Requirements
- R1: Op code 0 subtracts rt from rs in each of sixteen 8-bit lanes. Each lane wraps modulo 256, and no borrow crosses into the next lane.
- R2: Op code 1 does the same subtraction on eight 16-bit lanes, wrapping modulo 2^16.
- R3: Op code 2 does the same subtraction on four 32-bit lanes, wrapping modulo 2^32.
- R4: Op codes 3, 4, 5 and 6 give, over all 128 bits, rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt), in that order.
- R5: Op code 7 copies rt[15:0] into all four halfwords of result[63:0], and copies rt[79:64] into all four halfwords of result[127:64].
- R6: Op code 8 gives result[127:64] = rs[63:0] and result[63:0] = rt[63:0].
- R7: Op code 9 gives result[63:0] = rs[127:64] and result[127:64] = rt[127:64].
- R8: Op code 10 gives, from the lowest word to the highest, rt[95:64], rs[95:64], rt[127:96], rs[127:96].
- R9: When rs_zero is high the unit uses zero in place of rs_data. When rt_zero is high the unit uses zero in place of rt_data.
- R10: An accepted operation with destination index 0 leaves wb_en low in the output cycle.
- R11: Op codes 11 to 15 give an all-zero result with wb_en low.
- R12: An operation accepted on a clock edge drives res_valid, res_rd, res_data and wb_en from the next edge on. A cycle with in_valid low gives res_valid and wb_en low one clock later. wb_en is high only together with res_valid.
- R13: A synchronous active-high reset clears res_valid, wb_en, res_rd and res_data, and it takes priority over in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code |
| dst_idx | input | 5 | Destination register index |
| rs_data | input | 128 | First source operand |
| rt_data | input | 128 | Second source operand |
| rs_zero | input | 1 | Treat rs as zero |
| rt_zero | input | 1 | Treat rt as zero |
| res_valid | output | 1 | Registered result valid |
| res_rd | output | 5 | Registered destination index |
| res_data | output | 128 | Registered result |
| wb_en | output | 1 | Register file write enable |

## Verification
A wrong lane boundary in the subtractor lets a borrow leak into the neighbouring lane. That error shows in res_data on the very next clock, so the bench subtracts 1 from 0 in every lane. A crossed half or word in a permute also shows one clock after issue, because each operand is random and distinct. A stale or wrong writeback decision shows at wb_en one clock after issue. The bench sweeps all sixteen op codes, including the unused ones, and mixes in zero destinations and zero-operand flags.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_SUB_B  = 4'd0,
    OP_SUB_H  = 4'd1,
    OP_SUB_W  = 4'd2,
    OP_AND    = 4'd3,
    OP_OR     = 4'd4,
    OP_XOR    = 4'd5,
    OP_NOR    = 4'd6,
    OP_HBCAST = 4'd7,
    OP_CPY_LO = 4'd8,
    OP_CPY_HI = 4'd9,
    OP_ILV_UW = 4'd10
  } simd_op_e;

  localparam int unsigned OP_LAST = 10;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;

  typedef enum logic [1:0] {
    PM_HBCAST = 2'd0,
    PM_CPY_LO = 2'd1,
    PM_CPY_HI = 2'd2,
    PM_ILV_UW = 2'd3
  } perm_fn_e;
endpackage

// File: rtl/simd_lane_sub.sv
module simd_lane_sub #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] diff
);
  localparam int unsigned N_LANES = DATA_W / LANE_W;

  // One subtractor per lane: a borrow can never leave its lane.
  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    assign diff[i*LANE_W +: LANE_W] = a[i*LANE_W +: LANE_W] - b[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/simd_bitwise.sv
module simd_bitwise
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic_fn_e         fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (fn)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/simd_permute.sv
module simd_permute
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  perm_fn_e          fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned WORD_W = HALF_W / 2;
  localparam int unsigned HW_W   = HALF_W / 4;

  logic [DATA_W-1:0] bcast;

  // Halfword 0 of each half of b fills that same half.
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign bcast[h*HALF_W +: HALF_W] = {4{b[h*HALF_W +: HW_W]}};
  end

  always_comb begin
    unique case (fn)
      PM_HBCAST: y = bcast;
      PM_CPY_LO: y = {a[HALF_W-1:0], b[HALF_W-1:0]};
      PM_CPY_HI: y = {b[DATA_W-1:HALF_W], a[DATA_W-1:HALF_W]};
      default:   y = {a[HALF_W+WORD_W +: WORD_W], b[HALF_W+WORD_W +: WORD_W],
                      a[HALF_W +: WORD_W], b[HALF_W +: WORD_W]};
    endcase
  end
endmodule

// File: rtl/simd_exec_unit.sv
module simd_exec_unit
  import simd_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [DATA_W-1:0] rs_data,
  input  logic [DATA_W-1:0] rt_data,
  input  logic              rs_zero,
  input  logic              rt_zero,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_rd,
  output logic [DATA_W-1:0] res_data,
  output logic              wb_en
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HW_W   = DATA_W / 8;
  localparam int unsigned WORD_W = DATA_W / 4;

  logic [DATA_W-1:0] opa, opb;
  logic [DATA_W-1:0] sub_b, sub_h, sub_w, lg_y, pm_y;
  logic [DATA_W-1:0] res_d;
  logic              op_known;
  logic_fn_e         lg_fn;
  perm_fn_e          pm_fn;

  assign opa = rs_zero ? '0 : rs_data;
  assign opb = rt_zero ? '0 : rt_data;

  simd_lane_sub #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_sub_b (.a(opa), .b(opb), .diff(sub_b));
  simd_lane_sub #(.DATA_W(DATA_W), .LANE_W(HW_W))   u_sub_h (.a(opa), .b(opb), .diff(sub_h));
  simd_lane_sub #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_sub_w (.a(opa), .b(opb), .diff(sub_w));

  always_comb begin
    unique case (op_sel)
      OP_OR:   lg_fn = LG_OR;
      OP_XOR:  lg_fn = LG_XOR;
      OP_NOR:  lg_fn = LG_NOR;
      default: lg_fn = LG_AND;
    endcase
    unique case (op_sel)
      OP_CPY_LO: pm_fn = PM_CPY_LO;
      OP_CPY_HI: pm_fn = PM_CPY_HI;
      OP_ILV_UW: pm_fn = PM_ILV_UW;
      default:   pm_fn = PM_HBCAST;
    endcase
  end

  simd_bitwise #(.DATA_W(DATA_W)) u_logic (.fn(lg_fn), .a(opa), .b(opb), .y(lg_y));
  simd_permute #(.DATA_W(DATA_W)) u_perm  (.fn(pm_fn), .a(opa), .b(opb), .y(pm_y));

  always_comb begin
    op_known = 1'b1;
    case (op_sel)
      OP_SUB_B:                       res_d = sub_b;
      OP_SUB_H:                       res_d = sub_h;
      OP_SUB_W:                       res_d = sub_w;
      OP_AND, OP_OR, OP_XOR, OP_NOR:  res_d = lg_y;
      OP_HBCAST, OP_CPY_LO,
      OP_CPY_HI, OP_ILV_UW:           res_d = pm_y;
      default: begin
        res_d    = '0;
        op_known = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      wb_en     <= 1'b0;
      res_rd    <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid;
      wb_en     <= in_valid && op_known && (dst_idx != '0);
      if (in_valid) begin
        res_rd   <= dst_idx;
        res_data <= res_d;
      end
    end
  end
endmodule

// File: rtl/simd_exec_unit_chk.sv
module simd_exec_unit_chk #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned OP_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   op_sel,
  input logic [IDX_W-1:0]  dst_idx,
  input logic [DATA_W-1:0] rs_data,
  input logic [DATA_W-1:0] rt_data,
  input logic              rs_zero,
  input logic              rt_zero,
  input logic              res_valid,
  input logic [IDX_W-1:0]  res_rd,
  input logic [DATA_W-1:0] res_data,
  input logic              wb_en
);
  localparam int unsigned HALF_W = DATA_W / 2;

  p_issue_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid && res_rd == $past(dst_idx));
  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid && !wb_en);
  p_wb_valid_r12: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> res_valid);
  p_rd0_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid && dst_idx == '0 |=> !wb_en);
  p_badop_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel > 4'd10 |=> !wb_en && res_data == '0);
  p_cpylo_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel == 4'd8 && !rs_zero && !rt_zero |=>
      res_data == {$past(rs_data[HALF_W-1:0]), $past(rt_data[HALF_W-1:0])});
  p_zero_rs_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel == 4'd5 && rs_zero && !rt_zero |=> res_data == $past(rt_data));
endmodule

bind simd_exec_unit simd_exec_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .dst_idx(dst_idx),
  .rs_data(rs_data), .rt_data(rt_data), .rs_zero(rs_zero), .rt_zero(rt_zero),
  .res_valid(res_valid), .res_rd(res_rd), .res_data(res_data), .wb_en(wb_en)
);

// File: tb/simd_exec_unit_tb.sv
module simd_exec_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [3:0]   op_sel = '0;
  logic [4:0]   dst_idx = '0;
  logic [127:0] rs_data = '0, rt_data = '0;
  logic         rs_zero = 1'b0, rt_zero = 1'b0;
  logic         res_valid, wb_en;
  logic [4:0]   res_rd;
  logic [127:0] res_data;

  int checks = 0, errors = 0, cycles = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  simd_exec_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .dst_idx(dst_idx),
    .rs_data(rs_data), .rt_data(rt_data), .rs_zero(rs_zero), .rt_zero(rt_zero),
    .res_valid(res_valid), .res_rd(res_rd), .res_data(res_data), .wb_en(wb_en)
  );

  always #4 clk = ~clk;

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4, 4'd5, 4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      4'd10: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [127:0] model(input logic [3:0] o, input logic [127:0] a, b);
    logic [127:0] r = '0;
    case (o)
      4'd0: for (int i = 0; i < 16; i++) r[i*8 +: 8] = a[i*8 +: 8] - b[i*8 +: 8];
      4'd1: for (int i = 0; i < 8; i++) r[i*16 +: 16] = a[i*16 +: 16] - b[i*16 +: 16];
      4'd2: for (int i = 0; i < 4; i++) r[i*32 +: 32] = a[i*32 +: 32] - b[i*32 +: 32];
      4'd3: r = a & b;
      4'd4: r = a | b;
      4'd5: r = a ^ b;
      4'd6: r = ~(a | b);
      4'd7: for (int i = 0; i < 8; i++) r[i*16 +: 16] = (i < 4) ? b[15:0] : b[79:64];
      4'd8: begin r[127:64] = a[63:0]; r[63:0] = b[63:0]; end
      4'd9: begin r[63:0] = a[127:64]; r[127:64] = b[127:64]; end
      4'd10: begin
        r[31:0] = b[95:64]; r[63:32] = a[95:64];
        r[95:64] = b[127:96]; r[127:96] = a[127:96];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one operation at a falling edge and check it at the next falling edge.
  task automatic issue(input logic [3:0] o, input logic [4:0] d, input logic [127:0] x, y,
                       input logic zx, zy);
    logic [127:0] exp_r;
    logic         exp_wb;
    in_valid = 1'b1; op_sel = o; dst_idx = d;
    rs_data = x; rt_data = y; rs_zero = zx; rt_zero = zy;
    exp_r  = model(o, zx ? '0 : x, zy ? '0 : y);
    exp_wb = (o <= 4'd10) && (d != 5'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check(res_valid === 1'b1 && res_rd === d, "R12", {122'b0, res_valid, res_rd},
          {122'b0, 1'b1, d});
    check(res_data === exp_r, (zx || zy) ? {tag(o), "/R9"} : tag(o), res_data, exp_r);
    check(wb_en === exp_wb, (d == 5'd0) ? "R10" : tag(o), {127'b0, wb_en}, {127'b0, exp_wb});
  endtask

  task automatic idle_check();
    in_valid = 1'b0;
    @(negedge clk);
    check(res_valid === 1'b0 && wb_en === 1'b0, "R12", {126'b0, res_valid, wb_en}, '0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid === 1'b0 && wb_en === 1'b0 && res_data === '0, "R13",
          res_data | {126'b0, res_valid, wb_en}, '0);
    rst = 1'b0;
    @(negedge clk);

    // Borrow containment: 0 minus 1 in every lane (R1, R2, R3).
    issue(4'd0, 5'd3, '0, {16{8'h01}}, 1'b0, 1'b0);
    issue(4'd1, 5'd3, '0, {8{16'h0001}}, 1'b0, 1'b0);
    issue(4'd2, 5'd3, '0, {4{32'h00000001}}, 1'b0, 1'b0);
    issue(4'd0, 5'd4, {16{8'h80}}, {16{8'h7F}}, 1'b0, 1'b0);
    // Zero-operand flags (R9).
    issue(4'd5, 5'd7, {2{64'hDEADBEEF01234567}}, {2{64'h0F0F0F0F0F0F0F0F}}, 1'b1, 1'b0);
    issue(4'd7, 5'd7, {2{64'h1}}, {2{64'hFFFF}}, 1'b0, 1'b1);
    issue(4'd6, 5'd7, {2{64'h5}}, {2{64'h9}}, 1'b1, 1'b1);
    idle_check();

    // Sweep every op code with random operands, zero destinations and flags.
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 30; k++) begin
        issue(o[3:0], (k % 8 == 0) ? 5'd0 : k[4:0], {rnd(), rnd()}, {rnd(), rnd()},
              (k % 5 == 4), (k % 7 == 3));
      end
      idle_check();
    end

    // Reset overrides a valid issue (R13).
    in_valid = 1'b1; op_sel = 4'd3; dst_idx = 5'd9; rst = 1'b1;
    @(negedge clk);
    check(res_valid === 1'b0 && wb_en === 1'b0 && res_rd === 5'd0, "R13",
          {122'b0, res_valid, res_rd}, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule